// File: doc/BRIEF.md
# Byte-Level Serial EEPROM Target with Address Pointer

This block is the memory side of a two-wire serial EEPROM. It works at byte level and does no bit-level bus sampling. A front end decodes the bus and hands this block the bus events:
- a start (the first start or a repeated one);
- a stop;
- a received byte;
- a request for a read byte.

The block answers each received byte with an acknowledge pulse and each read request with a data byte. It holds an address pointer and a byte-wide memory array. The parameter `ADDR_BYTES` sets how many address bytes follow the write-addressed device byte: one or two.

The pointer and commit rules decide what a host sees when it probes the address width. The host writes a two-byte address, sends no stop, then issues a repeated start and a read.
- A one-byte part loads the pointer from the first byte and takes the second byte as data. The repeated start throws that data away, so the memory stays the same.
- A two-byte part loads both bytes into the pointer.

Written data sits in a page buffer until a stop arrives. The stop commits the buffer to the array and starts a busy interval. During the busy interval the part refuses its own address.

Top module: `eep_target`

## Requirements
- R1: The device byte carries the 7-bit device address in bits [7:1] and the direction in bit 0 (1 = read). The block acknowledges a device byte only when bits [7:1] equal `DEV_ADDR`. After any other device byte it gives no acknowledge and no read data until the next start.
- R2: With `ADDR_BYTES`=2, the two bytes after a write device byte are the pointer's high and low bytes, each acknowledged. Address bits at or above log2(`MEM_DEPTH`) are dropped.
- R3: With `ADDR_BYTES`=1, one byte after a write device byte loads the pointer. Every byte after it is data and leaves the pointer unchanged.
- R4: Data bytes are buffered and reach the array only on a stop. Byte n of a burst is written to slot (start offset + n) mod `PAGE_SIZE` of the page that holds the pointer.
- R5: A start or repeated start discards buffered data bytes and leaves the array unchanged.
- R6: A read request in the read state returns the byte at the pointer. When `AUTO_INC`=1, the pointer then advances by one and wraps from `MEM_DEPTH`-1 to 0.
- R7: After a commit with `AUTO_INC`=1, the pointer's in-page offset becomes (start offset + byte count) mod `PAGE_SIZE`. The page part of the pointer is kept.
- R8: For `WR_CYCLES` clocks after a commit, the block does not acknowledge its own device byte and treats that transfer as addressed elsewhere.
- R9: `ack_o` is a one-clock pulse in the cycle after an accepted `byte_valid_i`. `rd_valid_o` and `rd_data_o` appear in the cycle after `rd_req_i`. After reset both pulses are low, every array byte reads 8'hFF and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or repeated start seen on the bus |
| stop_i | input | 1 | Stop seen on the bus |
| byte_valid_i | input | 1 | A byte written by the host is on byte_i |
| byte_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Host clocks out one read byte |
| ack_o | output | 1 | Acknowledge pulse for the previous byte |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 8 | Read data byte |

## Verification
A wrong pointer shows up as a wrong data byte on the very next read request. A current-address read right after a commit therefore exposes both the pointer rule and the write-slot rule within one transfer. A wrong state register (a foreign address taken as a hit, an address byte taken as data) shows as an `ack_o` or `rd_valid_o` pulse one clock after the byte. A buffer that is not discarded, or a busy interval that is not kept, shows only after the next write burst, when that burst changes unrelated array bytes or gets acknowledged too early. For that reason the bench sets the pointer again and reads the whole page back after each such step.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WDATA,
    ST_READ,
    ST_IGNORE
  } eep_state_e;
endpackage

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int unsigned WR_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= CNT_W'(WR_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int unsigned PAGE_SIZE = 8,
  localparam int unsigned PG_W = $clog2(PAGE_SIZE)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       wr_i,
  input  logic [PG_W-1:0]            slot_i,
  input  logic [7:0]                 data_i,
  output logic [PAGE_SIZE-1:0][7:0]  data_o,
  output logic [PAGE_SIZE-1:0]       vld_o
);
  for (genvar s = 0; s < PAGE_SIZE; s++) begin : g_slot
    logic [7:0] d_q;
    logic       v_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_q <= '0;
        v_q <= 1'b0;
      end else if (clr_i) begin
        v_q <= 1'b0;
      end else if (wr_i && slot_i == PG_W'(s)) begin
        d_q <= data_i;
        v_q <= 1'b1;
      end
    end
    assign data_o[s] = d_q;
    assign vld_o[s]  = v_q;
  end
endmodule

// File: rtl/eep_mem_array.sv
module eep_mem_array #(
  parameter int unsigned MEM_DEPTH = 512,
  parameter int unsigned PAGE_SIZE = 8,
  localparam int unsigned PTR_W = $clog2(MEM_DEPTH),
  localparam int unsigned PG_W  = $clog2(PAGE_SIZE),
  localparam int unsigned PN_W  = PTR_W - PG_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      commit_i,
  input  logic [PN_W-1:0]           page_i,
  input  logic [PAGE_SIZE-1:0][7:0] pg_data_i,
  input  logic [PAGE_SIZE-1:0]      pg_vld_i,
  input  logic [PTR_W-1:0]          rd_addr_i,
  output logic [7:0]                rd_data_o
);
  logic [MEM_DEPTH-1:0][7:0] cells;

  for (genvar i = 0; i < MEM_DEPTH; i++) begin : g_cell
    localparam logic [PN_W-1:0] PG_ID = PN_W'(i / PAGE_SIZE);
    localparam int unsigned     SL    = i % PAGE_SIZE;
    logic [7:0] cell_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cell_q <= 8'hFF;  // erased state
      else if (commit_i && page_i == PG_ID && pg_vld_i[SL])
        cell_q <= pg_data_i[SL];
    end
    assign cells[i] = cell_q;
  end

  assign rd_data_o = cells[rd_addr_i];
endmodule

// File: rtl/eep_target.sv
module eep_target
  import eep_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR   = 7'h50,
  parameter int unsigned ADDR_BYTES = 2,
  parameter int unsigned MEM_DEPTH  = 512,
  parameter int unsigned PAGE_SIZE  = 8,
  parameter int unsigned WR_CYCLES  = 20,
  parameter bit          AUTO_INC   = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       rd_req_i,
  output logic       ack_o,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o
);
  localparam int unsigned PTR_W = $clog2(MEM_DEPTH);
  localparam int unsigned PG_W  = $clog2(PAGE_SIZE);

  eep_state_e st;
  logic [PTR_W-1:0] ptr, ptr_load;
  logic [7:0]       hi_q;
  logic [PG_W-1:0]  wcnt, slot;
  logic             busy, commit, buf_clr, buf_wr, addr_hit;
  logic [PAGE_SIZE-1:0][7:0] buf_data;
  logic [PAGE_SIZE-1:0]      buf_vld;
  logic [7:0]       mem_rd;

  assign slot     = ptr[PG_W-1:0] + wcnt;
  assign addr_hit = (byte_i[7:1] == DEV_ADDR) && !busy;
  assign commit   = stop_i && !start_i && (st == ST_WDATA) && (|buf_vld);
  assign buf_clr  = start_i || stop_i;
  assign buf_wr   = byte_valid_i && !buf_clr && (st == ST_WDATA);

  if (ADDR_BYTES == 2) begin : g_addr2
    assign ptr_load = PTR_W'({hi_q, byte_i});
  end else begin : g_addr1
    assign ptr_load = PTR_W'(byte_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= ST_IDLE;
      ptr        <= '0;
      hi_q       <= '0;
      wcnt       <= '0;
      ack_o      <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      ack_o      <= 1'b0;
      rd_valid_o <= 1'b0;
      if (start_i) begin
        st   <= ST_DEVADDR;
        wcnt <= '0;
      end else if (stop_i) begin
        st   <= ST_IDLE;
        wcnt <= '0;
        if (commit && AUTO_INC) ptr[PG_W-1:0] <= slot;
      end else begin
        if (byte_valid_i) begin
          unique case (st)
            ST_DEVADDR: begin
              if (addr_hit) begin
                ack_o <= 1'b1;
                if (byte_i[0])            st <= ST_READ;
                else if (ADDR_BYTES == 2) st <= ST_ADDR_HI;
                else                      st <= ST_ADDR_LO;
              end else begin
                st <= ST_IGNORE;
              end
            end
            ST_ADDR_HI: begin
              ack_o <= 1'b1;
              hi_q  <= byte_i;
              st    <= ST_ADDR_LO;
            end
            ST_ADDR_LO: begin
              ack_o <= 1'b1;
              ptr   <= ptr_load;  // pointer takes effect before any data
              wcnt  <= '0;
              st    <= ST_WDATA;
            end
            ST_WDATA: begin
              ack_o <= 1'b1;
              wcnt  <= wcnt + 1'b1;
            end
            default: ;
          endcase
        end
        if (rd_req_i && st == ST_READ) begin
          rd_valid_o <= 1'b1;
          rd_data_o  <= mem_rd;
          if (AUTO_INC) ptr <= ptr + 1'b1;
        end
      end
    end
  end

  eep_page_buf #(.PAGE_SIZE(PAGE_SIZE)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (buf_clr),
    .wr_i   (buf_wr),
    .slot_i (slot),
    .data_i (byte_i),
    .data_o (buf_data),
    .vld_o  (buf_vld)
  );

  eep_mem_array #(.MEM_DEPTH(MEM_DEPTH), .PAGE_SIZE(PAGE_SIZE)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (commit),
    .page_i    (ptr[PTR_W-1:PG_W]),
    .pg_data_i (buf_data),
    .pg_vld_i  (buf_vld),
    .rd_addr_i (ptr),
    .rd_data_o (mem_rd)
  );

  eep_busy_timer #(.WR_CYCLES(WR_CYCLES)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (commit),
    .busy_o (busy)
  );
endmodule

// File: rtl/eep_chk.sv
module eep_chk
  import eep_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       stop_i,
  input logic       byte_valid_i,
  input logic       rd_req_i,
  input logic       ack_o,
  input logic       rd_valid_o,
  input logic       busy,
  input logic       commit,
  input eep_state_e st
);
  AST_IGNORE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IGNORE && !start_i) |=> (!ack_o && !rd_valid_o)); // R1

  AST_COMMIT_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> (stop_i && !start_i && $past(st != ST_IDLE))); // R4

  AST_START_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i) |-> !commit); // R5

  AST_RD_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_req_i)); // R6

  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> busy); // R8

  AST_NACK_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && st == ST_DEVADDR && byte_valid_i && !start_i && !stop_i) |=> !ack_o); // R8

  AST_ACK_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(byte_valid_i)); // R9
endmodule

bind eep_target eep_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .byte_valid_i (byte_valid_i),
  .rd_req_i     (rd_req_i),
  .ack_o        (ack_o),
  .rd_valid_o   (rd_valid_o),
  .busy         (busy),
  .commit       (commit),
  .st           (st)
);

// File: tb/sim_eep_target.sv
`timescale 1ns/1ps
module sim_eep_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, bv = 1'b0, rdq = 1'b0;
  logic [7:0] b = '0;
  logic ack0, ack1, rv0, rv1;
  logic [7:0] rd0, rd1;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  // two-byte address part at 0x50 (bytes A0/A1)
  eep_target #(.DEV_ADDR(7'h50), .ADDR_BYTES(2), .MEM_DEPTH(512), .PAGE_SIZE(8),
               .WR_CYCLES(20), .AUTO_INC(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .byte_valid_i(bv),
    .byte_i(b), .rd_req_i(rdq), .ack_o(ack0), .rd_valid_o(rv0), .rd_data_o(rd0));

  // one-byte address part at 0x51 (bytes A2/A3)
  eep_target #(.DEV_ADDR(7'h51), .ADDR_BYTES(1), .MEM_DEPTH(256), .PAGE_SIZE(8),
               .WR_CYCLES(20), .AUTO_INC(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .byte_valid_i(bv),
    .byte_i(b), .rd_req_i(rdq), .ack_o(ack1), .rd_valid_o(rv1), .rd_data_o(rd1));

  function automatic logic [7:0] pat0(int i); return 8'((i * 37 + 11) & 255); endfunction
  function automatic logic [7:0] pat1(int i); return 8'((i * 53 + 195) & 255); endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(); start = 1'b1; @(negedge clk); start = 1'b0; endtask
  task automatic do_stop();  stop  = 1'b1; @(negedge clk); stop  = 1'b0; endtask
  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic send(input logic [7:0] v, output logic a0, output logic a1);
    b = v; bv = 1'b1;
    @(negedge clk);
    a0 = ack0; a1 = ack1; bv = 1'b0;
  endtask

  task automatic rd(output logic v0, output logic [7:0] d0, output logic v1, output logic [7:0] d1);
    rdq = 1'b1;
    @(negedge clk);
    v0 = rv0; d0 = rd0; v1 = rv1; d1 = rd1; rdq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic a0, a1, v0, v1;
    logic [7:0] d0, d1;
    idle(3);
    // R9 reset state
    chk(ack0 == 0 && ack1 == 0 && rv0 == 0 && rv1 == 0, "R9 reset pulses", {ack0, ack1, rv0, rv1}, 0);
    rst_n = 1'b1;
    idle(2);
    // R9 erased array, pointer 0
    do_start(); send(8'hA1, a0, a1);
    chk(a0 == 1 && a1 == 0, "R1 read addr hit", {a0, a1}, 2);
    rd(v0, d0, v1, d1);
    chk(v0 == 1 && d0 == 8'hFF && v1 == 0, "R9 erased read", {v0, d0}, 'h1FF);
    do_stop();

    // fill page 0 of u1 (one address byte)
    do_start(); send(8'hA2, a0, a1);
    chk(a1 == 1 && a0 == 0, "R1 write addr hit", {a0, a1}, 1);
    send(8'h00, a0, a1);
    for (int i = 0; i < 8; i++) send(pat1(i), a0, a1);
    chk(a1 == 1, "R4 data ack", a1, 1);
    do_stop(); idle(30);

    // fill page 0 of u0 (two address bytes)
    do_start(); send(8'hA0, a0, a1); send(8'h00, a0, a1); send(8'h00, a0, a1);
    chk(a0 == 1, "R2 low addr ack", a0, 1);
    for (int i = 0; i < 8; i++) send(pat0(i), a0, a1);
    do_stop();
    // R8 busy NACK
    do_start(); send(8'hA0, a0, a1);
    chk(a0 == 0, "R8 busy nack", a0, 0);
    send(8'h00, a0, a1);
    chk(a0 == 0, "R8 busy ignored", a0, 0);
    do_stop(); idle(30);
    do_start(); send(8'hA0, a0, a1);
    chk(a0 == 1, "R8 ack after busy", a0, 1);
    do_stop();

    // R2 two-byte probe
    for (int k = 0; k < 8; k++) begin
      do_start(); send(8'hA0, a0, a1); send(8'h00, a0, a1); send(8'(k), a0, a1);
      do_start(); send(8'hA1, a0, a1);
      rd(v0, d0, v1, d1);
      chk(v0 == 1 && d0 == pat0(k), "R2 probe read", d0, pat0(k));
      rd(v0, d0, v1, d1);
      chk(d0 == ((k < 7) ? pat0(k + 1) : 8'hFF), "R6 auto increment", d0, (k < 7) ? pat0(k + 1) : 8'hFF);
      do_stop();
    end

    // R3 one-byte probe: second byte is data, pointer stays 0
    for (int k = 0; k < 8; k++) begin
      do_start(); send(8'hA2, a0, a1); send(8'h00, a0, a1); send(8'(k), a0, a1);
      do_start(); send(8'hA3, a0, a1);
      rd(v0, d0, v1, d1);
      chk(v1 == 1 && d1 == pat1(0), "R3 probe read", d1, pat1(0));
      do_stop();
    end
    // R5 discarded bytes left array unchanged
    idle(30);
    do_start(); send(8'hA2, a0, a1); send(8'h00, a0, a1);
    do_start(); send(8'hA3, a0, a1);
    for (int i = 0; i < 8; i++) begin
      rd(v0, d0, v1, d1);
      chk(d1 == pat1(i), "R5 unchanged", d1, pat1(i));
    end
    do_stop();

    // R4 page wrap: 4 bytes from offset 6 go to 6,7,0,1
    do_start(); send(8'hA2, a0, a1); send(8'h06, a0, a1);
    for (int j = 0; j < 4; j++) send(8'(8'h10 + j), a0, a1);
    do_stop(); idle(30);
    // R7 current address read after commit -> offset 2
    do_start(); send(8'hA3, a0, a1);
    rd(v0, d0, v1, d1);
    chk(d1 == pat1(2), "R7 pointer after commit", d1, pat1(2));
    do_stop();
    do_start(); send(8'hA2, a0, a1); send(8'h00, a0, a1);
    do_start(); send(8'hA3, a0, a1);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      e = (i == 0) ? 8'h12 : (i == 1) ? 8'h13 : (i == 6) ? 8'h10 : (i == 7) ? 8'h11 : pat1(i);
      rd(v0, d0, v1, d1);
      chk(d1 == e, "R4 page wrap", d1, e);
    end
    do_stop();

    // R6 wrap at array end
    do_start(); send(8'hA2, a0, a1); send(8'hFF, a0, a1);
    do_start(); send(8'hA3, a0, a1);
    rd(v0, d0, v1, d1);
    chk(d1 == 8'hFF, "R6 last cell", d1, 8'hFF);
    rd(v0, d0, v1, d1);
    chk(d1 == 8'h12, "R6 wrap to 0", d1, 8'h12);
    do_stop();

    // R2 high byte selects upper half
    do_start(); send(8'hA0, a0, a1); send(8'h01, a0, a1); send(8'h05, a0, a1); send(8'h77, a0, a1);
    do_stop(); idle(30);
    do_start(); send(8'hA0, a0, a1); send(8'h00, a0, a1); send(8'h05, a0, a1);
    do_start(); send(8'hA1, a0, a1);
    rd(v0, d0, v1, d1);
    chk(d0 == pat0(5), "R2 low half kept", d0, pat0(5));
    do_start(); send(8'hA0, a0, a1); send(8'h01, a0, a1); send(8'h05, a0, a1);
    do_start(); send(8'hA1, a0, a1);
    rd(v0, d0, v1, d1);
    chk(d0 == 8'h77, "R2 high byte", d0, 8'h77);
    do_stop();

    // R1 foreign address
    do_start(); send(8'h88, a0, a1);
    chk(a0 == 0 && a1 == 0, "R1 foreign nack", {a0, a1}, 0);
    send(8'h00, a0, a1);
    chk(a0 == 0 && a1 == 0, "R1 foreign byte", {a0, a1}, 0);
    rd(v0, d0, v1, d1);
    chk(v0 == 0 && v1 == 0, "R1 foreign read", {v0, v1}, 0);
    do_stop();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule